// File: doc/BRIEF.md
# Maskable Interrupt Priority Resolver

This block sits between the peripheral request flags and the CPU's exception entry logic. Each cycle it looks at every maskable request and its local enable, applies the CPU's global interrupt mask, and names one winning vector. The output is a pending flag plus the winner's vector-table index and vector address. The winner and the pending flag follow the current inputs with no register in the path.

By default the vectors are ranked by their table index, and the lowest index wins. Software can raise any one vector above all the others by writing its index into a 4-bit priority-select register. That register only accepts a write while the global mask is set, so it cannot change while a maskable interrupt could be taken.

Vector 0 is the external request pin, which has no local enable. Vectors 1 to 13 each have one request with one enable. Vector 14 collects the five serial-port conditions, which are gated by four enable bits.

Top module: `irq_prio_resolver`

## Requirements
- R1: While `i_mask` is 1, `irq_pending` is 0 whatever the requests.
- R2: A request on vectors 1 to 13 counts only when its bit in `src_en` is 1. Vector 0, the external pin, counts with no enable, and `src_en[0]` is ignored.
- R3: With no promotion in force, the qualified vector with the lowest index wins.
- R4: The priority-select register resets to 0. A `psel_we` pulse loads `psel_wdata` at that clock edge only if `i_mask` is 1. With `i_mask` at 0 the write is ignored. `psel_rd` shows the stored value from the cycle after the edge.
- R5: If the stored select value is a qualified vector, that vector wins over all the others. A select value that is not qualified, or that is 15 (no such vector), leaves the default order of R3 in force.
- R6: Vector 14 counts when any serial condition is set together with its enable. The `sci_flags` bits are: bit 0 transmit done (`sci_en` bit 0), bit 1 transmit register empty (`sci_en` bit 1), bit 2 idle line (`sci_en` bit 2), bit 3 overrun (`sci_en` bit 3) and bit 4 receive full (`sci_en` bit 3).
- R7: While a vector is pending, `win_vector` = 0xFFF2 − 2 × `win_index`, which places vector 14 at 0xFFD6. While nothing is pending, `win_index` and `win_vector` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_mask | input | 1 | Global maskable-interrupt mask (1 = masked) |
| src_req | input | 14 | Requests for vectors 0 to 13 |
| src_en | input | 14 | Local enables for vectors 0 to 13 (bit 0 unused) |
| sci_flags | input | 5 | Serial-port condition flags |
| sci_en | input | 4 | Serial-port enable bits |
| psel_we | input | 1 | Write strobe for the priority-select register |
| psel_wdata | input | 4 | Value to write to the priority-select register |
| psel_rd | output | 4 | Stored priority-select value |
| irq_pending | output | 1 | At least one qualified maskable request |
| win_index | output | 4 | Vector-table index of the winner |
| win_vector | output | 16 | Vector address of the winner |

## Verification
The bench builds the block with its default parameters: 15 vectors, a 4-bit select field and a base address of 0xFFF2. With these values the serial vector falls at 0xFFD6. They also leave select value 15 unused, so the bench can drive a select value that names no vector. Since every index is reachable, the bench can promote the highest-numbered vector over a lower one as well as a middle one. It also covers a promoted vector that is disabled or not requesting, and each serial enable on its own.

// File: rtl/irq_pkg.sv
package irq_pkg;
    // Bit positions of the serial-port condition flags
    localparam int SCI_TXDONE  = 0;
    localparam int SCI_TXEMPTY = 1;
    localparam int SCI_IDLE    = 2;
    localparam int SCI_OVERRUN = 3;
    localparam int SCI_RXFULL  = 4;
    localparam int SCI_FLAGS   = 5;

    // Bit positions of the serial-port enables
    localparam int SCIE_TXDONE  = 0;
    localparam int SCIE_TXEMPTY = 1;
    localparam int SCIE_IDLE    = 2;
    localparam int SCIE_RX      = 3;
    localparam int SCI_ENS      = 4;

    // Vector address of a table index: base minus two bytes per entry
    function automatic logic [15:0] vec_addr(input logic [15:0] base, input logic [3:0] idx);
        return base - {11'd0, idx, 1'b0};
    endfunction
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_pkg::*;
#(
    parameter int NUM_VEC = 15
) (
    input  logic                   i_mask,
    input  logic [NUM_VEC-2:0]     src_req,
    input  logic [NUM_VEC-2:0]     src_en,
    input  logic [SCI_FLAGS-1:0]   sci_flags,
    input  logic [SCI_ENS-1:0]     sci_en,
    output logic [NUM_VEC-1:0]     qual
);
    localparam int SCI_IDX = NUM_VEC - 1;

    logic [SCI_FLAGS-1:0] sci_gate;
    logic                 sci_any;

    // Each serial condition paired with the enable that gates it (R6)
    always_comb begin
        sci_gate               = '0;
        sci_gate[SCI_TXDONE]   = sci_en[SCIE_TXDONE];
        sci_gate[SCI_TXEMPTY]  = sci_en[SCIE_TXEMPTY];
        sci_gate[SCI_IDLE]     = sci_en[SCIE_IDLE];
        sci_gate[SCI_OVERRUN]  = sci_en[SCIE_RX];
        sci_gate[SCI_RXFULL]   = sci_en[SCIE_RX];
        sci_any                = |(sci_flags & sci_gate);
    end

    // Vector 0 needs no local enable; the rest do (R2). The global mask blocks all (R1).
    for (genvar g = 0; g < NUM_VEC - 1; g++) begin : g_vec
        if (g == 0) begin : g_pin
            assign qual[g] = !i_mask && src_req[g];
        end else begin : g_loc
            assign qual[g] = !i_mask && src_req[g] && src_en[g];
        end
    end
    assign qual[SCI_IDX] = !i_mask && sci_any;
endmodule

// File: rtl/irq_psel_reg.sv
module irq_psel_reg #(
    parameter int               SEL_W    = 4,
    parameter logic [SEL_W-1:0] PSEL_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_mask,
    input  logic             psel_we,
    input  logic [SEL_W-1:0] psel_wdata,
    output logic [SEL_W-1:0] psel_q
);
    // A write is accepted only while maskable interrupts are globally blocked (R4)
    always_ff @(posedge clk) begin
        if (!rst_n)
            psel_q <= PSEL_RST;
        else if (psel_we && i_mask)
            psel_q <= psel_wdata;
    end

    AST_PSEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !i_mask |=> $stable(psel_q)); // R4
    AST_PSEL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_we && i_mask) |=> (psel_q == $past(psel_wdata))); // R4
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_VEC = 15,
    parameter int SEL_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_VEC-1:0]  qual,
    input  logic [SEL_W-1:0]    psel,
    output logic                pending,
    output logic [SEL_W-1:0]    win_idx
);
    localparam int               SPAN = 2 ** SEL_W;
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_VEC - 1);

    logic [SPAN-1:0]    qual_x;
    logic [NUM_VEC-1:0] dflt_grant;
    logic [NUM_VEC-1:0] prom_grant;
    logic [NUM_VEC-1:0] grant;
    logic               promote;

    assign qual_x     = SPAN'(qual);
    // Isolate the lowest set bit: default order, lowest index wins (R3)
    assign dflt_grant = qual & (~qual + NUM_VEC'(1));
    // A promotion needs the select to name a vector that is qualified (R5)
    assign promote    = (psel <= LAST) && qual_x[psel];
    assign prom_grant = NUM_VEC'(1) << psel;
    assign grant      = promote ? prom_grant : dflt_grant;
    assign pending    = |qual;

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_VEC; i++)
            if (grant[i]) win_idx = win_idx | SEL_W'(i);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R3
    AST_WINNER_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> qual_x[win_idx]); // R3
    AST_NONE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && win_idx != psel) |-> ((qual & ((NUM_VEC'(1) << win_idx) - NUM_VEC'(1))) == '0)); // R3
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_pkg::*;
#(
    parameter int          NUM_VEC  = 15,
    parameter int          SEL_W    = 4,
    parameter logic [15:0] VEC_BASE = 16'hFFF2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  i_mask,
    input  logic [NUM_VEC-2:0]    src_req,
    input  logic [NUM_VEC-2:0]    src_en,
    input  logic [SCI_FLAGS-1:0]  sci_flags,
    input  logic [SCI_ENS-1:0]    sci_en,
    input  logic                  psel_we,
    input  logic [SEL_W-1:0]      psel_wdata,
    output logic [SEL_W-1:0]      psel_rd,
    output logic                  irq_pending,
    output logic [SEL_W-1:0]      win_index,
    output logic [15:0]           win_vector
);
    localparam int SPAN = 2 ** SEL_W;

    logic [NUM_VEC-1:0] qual;
    logic [SEL_W-1:0]   pick_idx;
    logic [SPAN-1:0]    en_x;

    irq_qualify #(.NUM_VEC(NUM_VEC)) u_qual (
        .i_mask    (i_mask),
        .src_req   (src_req),
        .src_en    (src_en),
        .sci_flags (sci_flags),
        .sci_en    (sci_en),
        .qual      (qual)
    );

    irq_psel_reg #(.SEL_W(SEL_W), .PSEL_RST('0)) u_psel (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_mask     (i_mask),
        .psel_we    (psel_we),
        .psel_wdata (psel_wdata),
        .psel_q     (psel_rd)
    );

    irq_pick #(.NUM_VEC(NUM_VEC), .SEL_W(SEL_W)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .qual    (qual),
        .psel    (psel_rd),
        .pending (irq_pending),
        .win_idx (pick_idx)
    );

    // Idle outputs are zero (R7)
    assign win_index  = irq_pending ? pick_idx : '0;
    assign win_vector = irq_pending ? vec_addr(VEC_BASE, 4'(pick_idx)) : 16'h0000;

    assign en_x = SPAN'(src_en);

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        i_mask |-> !irq_pending); // R1
    AST_LOCAL_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && win_index != '0 && win_index < SEL_W'(NUM_VEC - 1)) |-> en_x[win_index]); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending |-> (win_index == '0 && win_vector == 16'h0000)); // R7
endmodule

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;
    typedef struct packed {
        logic [3:0]  rq;
        logic [3:0]  psel;
        logic        imask;
        logic [13:0] req;
        logic [13:0] en;
        logic [4:0]  sflg;
        logic [3:0]  sen;
        logic        pend;
        logic [3:0]  idx;
    } row_t;

    localparam int NROWS = 16;
    // rq, psel, imask, req, en, sci_flags, sci_en, pending, index
    localparam row_t ROWS [NROWS] = '{
        '{4'd7, 4'd15, 1'b0, 14'h0000, 14'h3FFF, 5'b00000, 4'b0000, 1'b0, 4'd0},  // R7 idle
        '{4'd3, 4'd15, 1'b0, 14'h0024, 14'h3FFF, 5'b00000, 4'b0000, 1'b1, 4'd2},  // R3 lowest wins
        '{4'd1, 4'd15, 1'b1, 14'h0024, 14'h3FFF, 5'b11111, 4'b1111, 1'b0, 4'd0},  // R1 masked
        '{4'd2, 4'd15, 1'b0, 14'h0024, 14'h3FFB, 5'b00000, 4'b0000, 1'b1, 4'd5},  // R2 enable off
        '{4'd2, 4'd15, 1'b0, 14'h0001, 14'h0000, 5'b00000, 4'b0000, 1'b1, 4'd0},  // R2 pin no enable
        '{4'd5, 4'd5,  1'b0, 14'h0024, 14'h3FFF, 5'b00000, 4'b0000, 1'b1, 4'd5},  // R5 promote
        '{4'd5, 4'd5,  1'b0, 14'h0004, 14'h3FFF, 5'b00000, 4'b0000, 1'b1, 4'd2},  // R5 not requesting
        '{4'd5, 4'd5,  1'b0, 14'h0024, 14'h3FDF, 5'b00000, 4'b0000, 1'b1, 4'd2},  // R5 not enabled
        '{4'd6, 4'd15, 1'b0, 14'h0000, 14'h3FFF, 5'b00001, 4'b0001, 1'b1, 4'd14}, // R6 tx done
        '{4'd6, 4'd15, 1'b0, 14'h0000, 14'h3FFF, 5'b10000, 4'b0111, 1'b0, 4'd0},  // R6 rx gated off
        '{4'd6, 4'd15, 1'b0, 14'h0000, 14'h3FFF, 5'b01000, 4'b1000, 1'b1, 4'd14}, // R6 overrun
        '{4'd6, 4'd15, 1'b0, 14'h0000, 14'h3FFF, 5'b00100, 4'b0100, 1'b1, 4'd14}, // R6 idle line
        '{4'd6, 4'd15, 1'b0, 14'h0000, 14'h3FFF, 5'b00010, 4'b1101, 1'b0, 4'd0},  // R6 tx empty off
        '{4'd5, 4'd14, 1'b0, 14'h2000, 14'h3FFF, 5'b00001, 4'b0001, 1'b1, 4'd14}, // R5 promote last
        '{4'd3, 4'd0,  1'b0, 14'h0009, 14'h3FFF, 5'b00000, 4'b0000, 1'b1, 4'd0},  // R3 pin first
        '{4'd5, 4'd15, 1'b0, 14'h2008, 14'h3FFF, 5'b00000, 4'b0000, 1'b1, 4'd3}   // R5 select 15
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_mask = 1'b1;
    logic [13:0] src_req = '0;
    logic [13:0] src_en = '0;
    logic [4:0]  sci_flags = '0;
    logic [3:0]  sci_en = '0;
    logic        psel_we = 1'b0;
    logic [3:0]  psel_wdata = '0;
    logic [3:0]  psel_rd;
    logic        irq_pending;
    logic [3:0]  win_index;
    logic [15:0] win_vector;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_prio_resolver uut (
        .clk(clk), .rst_n(rst_n), .i_mask(i_mask), .src_req(src_req), .src_en(src_en),
        .sci_flags(sci_flags), .sci_en(sci_en), .psel_we(psel_we), .psel_wdata(psel_wdata),
        .psel_rd(psel_rd), .irq_pending(irq_pending), .win_index(win_index), .win_vector(win_vector)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_psel(input logic mask, input logic [3:0] v);
        @(negedge clk);
        i_mask = mask; psel_we = 1'b1; psel_wdata = v;
        @(negedge clk);
        psel_we = 1'b0;
    endtask

    function automatic logic [15:0] exp_vec(input logic p, input logic [3:0] i);
        return p ? 16'hFFF2 - {11'd0, i, 1'b0} : 16'h0000;
    endfunction

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R4 reset select", 32'(psel_rd), 32'd0);
        check("R1 reset masked pending", 32'(irq_pending), 32'd0);

        for (int r = 0; r < NROWS; r++) begin
            write_psel(1'b1, ROWS[r].psel);
            @(negedge clk);
            i_mask = ROWS[r].imask; src_req = ROWS[r].req; src_en = ROWS[r].en;
            sci_flags = ROWS[r].sflg; sci_en = ROWS[r].sen;
            #2;
            check($sformatf("R%0d row %0d pending", ROWS[r].rq, r), 32'(irq_pending), 32'(ROWS[r].pend));
            check($sformatf("R%0d row %0d index", ROWS[r].rq, r), 32'(win_index), 32'(ROWS[r].idx));
            check($sformatf("R7 row %0d vector", r), 32'(win_vector), 32'(exp_vec(ROWS[r].pend, ROWS[r].idx)));
        end

        // R4: write while unmasked is ignored
        write_psel(1'b1, 4'd9);
        #2 check("R4 masked write taken", 32'(psel_rd), 32'd9);
        write_psel(1'b0, 4'd4);
        #2 check("R4 unmasked write ignored", 32'(psel_rd), 32'd9);
        // select 9 still steers the winner, not 4
        @(negedge clk);
        i_mask = 1'b0; src_req = 14'h0210; src_en = 14'h3FFF; sci_flags = '0; sci_en = '0;
        #2 check("R4 R5 ignored write keeps promotion", 32'(win_index), 32'd9);
        // R7: serial vector address
        src_req = '0; sci_flags = 5'b10000; sci_en = 4'b1000;
        #2 check("R7 serial vector", 32'(win_vector), 32'hFFD6);
        // R1: raising the mask drops everything
        i_mask = 1'b1;
        #2 check("R1 mask set", 32'(irq_pending), 32'd0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule